// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block is the part of a small 8-bit processor that moves machine state to and from the stack around an exception. When the core takes an interrupt, it copies a snapshot of its register file into the block. The block then writes nine bytes onto a descending stack over a single-port byte bus. After the last write it raises the mask bits in the flags byte. Finally it reads a two-byte vector, which becomes the new program counter. A return command reverses the process: the same nine bytes are read back from the stack and restore every register, including the mask bits.

A wait command stacks the context ahead of time and then parks the sequencer. While parked, the bus keeps reading the stack slot that holds the saved flags byte. A later interrupt request leaves the parked state and goes straight to the vector fetch, without stacking again. For an illegal-opcode trap, the core supplies the address of the first byte of the offending opcode, and that address is saved in place of the current program counter.

The bus carries one byte access per clock. The address is a function of registered state only. Read data is taken on the clock edge that ends the cycle in which the address is presented. While a sequence runs, `busy` is high, and commands that arrive during that time are ignored.

Top module: `ctx_sequencer`

## Requirements
- R1: On `reqTake`, nine write cycles follow in consecutive clocks. They store, at SP, SP-1, ..., SP-8 in turn: PC low, PC high, IY low, IY high, IX low, IX high, accumulator A, accumulator B, flags. SP is the `spIn` value at the time of the request.
- R2: After any stacking, `spOut` equals the starting SP minus 9. Each push decrements SP by one.
- R3: The flags byte written to the stack is the flags value from before the interrupt. After that write, flags bit 4 (I) is set in `ccrOut`. Flags bit 6 (X) is also set only when `reqNmi` was high with the request. All other flag bits are unchanged.
- R4: After stacking, two reads fetch the vector: the high byte from `vecAddr`, then the low byte from `vecAddr`+1. `pcOut` then holds {high, low}, and `done` pulses for one cycle with `busy` low.
- R5: On `cmdRti`, nine reads at SP+1 through SP+9 restore flags, B, A, IX high, IX low, IY high, IY low, PC high and PC low, in that order. `spOut` ends at SP+9.
- R6: When `reqTrap` accompanies `reqTake`, the stacked return address is `trapPc` and not `pcIn`.
- R7: On `cmdWait`, the nine bytes are stacked as in R1 and no mask bit changes. After that, `inWait` is high and every cycle is a read at SP+1, the address of the saved flags byte, with no writes.
- R8: A `reqTake` while `inWait` is high causes no further stack writes. It sets the mask bits as in R3 and performs the R4 vector fetch.
- R9: While `busy` is high, `reqTake`, `cmdWait` and `cmdRti` have no effect.
- R10: After reset, `busy`, `done`, `inWait`, `memWe` and `memRe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqTake | input | 1 | Take an already-qualified interrupt (one-cycle pulse) |
| reqNmi | input | 1 | Request is the non-maskable source |
| reqTrap | input | 1 | Request is an illegal-opcode trap |
| trapPc | input | 16 | Address of the first byte of the offending opcode |
| vecAddr | input | 16 | Even address of the vector for this request |
| cmdWait | input | 1 | Enter wait: stack context, then park |
| cmdRti | input | 1 | Return from interrupt: unstack context |
| pcIn | input | 16 | Snapshot: program counter |
| ixIn | input | 16 | Snapshot: index X |
| iyIn | input | 16 | Snapshot: index Y |
| accAIn | input | 8 | Snapshot: accumulator A |
| accBIn | input | 8 | Snapshot: accumulator B |
| ccrIn | input | 8 | Snapshot: flags byte |
| spIn | input | 16 | Snapshot: stack pointer |
| memAddr | output | 16 | Bus address |
| memWe | output | 1 | Bus write this cycle |
| memRe | output | 1 | Bus read this cycle |
| memWdata | output | 8 | Bus write data |
| memRdata | input | 8 | Bus read data |
| pcOut | output | 16 | Working program counter |
| ixOut | output | 16 | Working index X |
| iyOut | output | 16 | Working index Y |
| accAOut | output | 8 | Working accumulator A |
| accBOut | output | 8 | Working accumulator B |
| ccrOut | output | 8 | Working flags byte |
| spOut | output | 16 | Working stack pointer |
| busy | output | 1 | A sequence or the parked wait state is active |
| done | output | 1 | One-cycle pulse when entry or return completes |
| inWait | output | 1 | Parked in wait, context already stacked |

## Verification
The checks assume several things about the inputs:
- Commands arrive as one-cycle pulses.
- `memRdata` is valid in the same cycle as the read address.
- Any masking of `reqTake` against the I and X bits has already been done outside the block.
- `vecAddr` is even.

The bench drives every input on the falling edge from the bench's own tasks, so these conditions hold. It issues commands only while the block is idle or parked, with one exception: a deliberate test that fires commands into a running sequence to confirm they are dropped. The bench memory returns data combinationally from the address the block presents.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  parameter int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int STACK_BYTES = 9;
  localparam int SLOT_W = $clog2(STACK_BYTES);
  localparam int BIT_X = 6;
  localparam int BIT_I = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_PULL, ST_WAIT, ST_VECH, ST_VECL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadSnap;
    logic              pushEn;
    logic              pullEn;
    logic              setMask;
    logic              vecHi;
    logic              vecLo;
    logic              waitRd;
    logic              wake;
    logic [SLOT_W-1:0] slot;
  } ctlStrobe_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqTake,
  input  logic       cmdWait,
  input  logic       cmdRti,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done,
  output logic       inWait
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(STACK_BYTES - 1);

  seqState_t         state;
  logic [SLOT_W-1:0] cnt;
  logic              waitEntry;
  logic              doneQ;

  always_comb begin
    ctl = '0;
    ctl.slot = cnt;
    unique case (state)
      ST_IDLE: ctl.loadSnap = reqTake | cmdWait | cmdRti;
      ST_PUSH: begin
        ctl.pushEn  = 1'b1;
        ctl.setMask = (cnt == LAST_SLOT) && !waitEntry;
      end
      ST_PULL: ctl.pullEn = 1'b1;
      ST_WAIT: begin
        ctl.waitRd  = 1'b1;
        ctl.wake    = reqTake;
        ctl.setMask = reqTake;
      end
      ST_VECH: ctl.vecHi = 1'b1;
      ST_VECL: ctl.vecLo = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      waitEntry <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqTake) begin
            state <= ST_PUSH; cnt <= '0; waitEntry <= 1'b0;
          end else if (cmdWait) begin
            state <= ST_PUSH; cnt <= '0; waitEntry <= 1'b1;
          end else if (cmdRti) begin
            state <= ST_PULL; cnt <= LAST_SLOT;
          end
        end
        ST_PUSH: begin
          if (cnt == LAST_SLOT) state <= waitEntry ? ST_WAIT : ST_VECH;
          else cnt <= cnt + 1'b1;
        end
        ST_PULL: begin
          if (cnt == '0) begin
            state <= ST_IDLE; doneQ <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_WAIT: if (reqTake) state <= ST_VECH;
        ST_VECH: state <= ST_VECL;
        ST_VECL: begin
          state <= ST_IDLE; doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;
  assign inWait = (state == ST_WAIT);
endmodule

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              reqNmi,
  input  logic              reqTrap,
  input  logic [ADDR_W-1:0] trapPc,
  input  logic [ADDR_W-1:0] vecAddr,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] ixIn,
  input  logic [ADDR_W-1:0] iyIn,
  input  logic [DATA_W-1:0] accAIn,
  input  logic [DATA_W-1:0] accBIn,
  input  logic [DATA_W-1:0] ccrIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] ixOut,
  output logic [ADDR_W-1:0] iyOut,
  output logic [DATA_W-1:0] accAOut,
  output logic [DATA_W-1:0] accBOut,
  output logic [DATA_W-1:0] ccrOut,
  output logic [ADDR_W-1:0] spOut
);
  logic [ADDR_W-1:0] pcR, ixR, iyR, spR, vecR;
  logic [DATA_W-1:0] aR, bR, ccrR;
  logic              nmiR, maskX;

  // byte leaving for stack slot k (slot 0 lands at the top address)
  always_comb begin
    unique case (ctl.slot)
      4'd0:    memWdata = pcR[0 +: DATA_W];
      4'd1:    memWdata = pcR[DATA_W +: DATA_W];
      4'd2:    memWdata = iyR[0 +: DATA_W];
      4'd3:    memWdata = iyR[DATA_W +: DATA_W];
      4'd4:    memWdata = ixR[0 +: DATA_W];
      4'd5:    memWdata = ixR[DATA_W +: DATA_W];
      4'd6:    memWdata = aR;
      4'd7:    memWdata = bR;
      default: memWdata = ccrR;
    endcase
  end

  always_comb begin
    if (ctl.pushEn)                    memAddr = spR;
    else if (ctl.pullEn || ctl.waitRd) memAddr = spR + ADDR_W'(1);
    else if (ctl.vecHi)                memAddr = vecR;
    else if (ctl.vecLo)                memAddr = vecR + ADDR_W'(1);
    else                               memAddr = '0;
  end

  assign memWe = ctl.pushEn;
  assign memRe = ctl.pullEn | ctl.waitRd | ctl.vecHi | ctl.vecLo;
  assign maskX = ctl.wake ? reqNmi : nmiR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR <= '0; ixR <= '0; iyR <= '0; spR <= '0; vecR <= '0;
      aR <= '0; bR <= '0; ccrR <= '0; nmiR <= 1'b0;
    end else begin
      if (ctl.loadSnap) begin
        pcR  <= reqTrap ? trapPc : pcIn;
        ixR  <= ixIn;
        iyR  <= iyIn;
        aR   <= accAIn;
        bR   <= accBIn;
        ccrR <= ccrIn;
        spR  <= spIn;
      end
      if (ctl.loadSnap || ctl.wake) begin
        vecR <= vecAddr;
        nmiR <= reqNmi;
      end
      if (ctl.pushEn) spR <= spR - ADDR_W'(1);
      if (ctl.setMask) begin
        ccrR[BIT_I] <= 1'b1;
        if (maskX) ccrR[BIT_X] <= 1'b1;
      end
      if (ctl.pullEn) begin
        spR <= spR + ADDR_W'(1);
        unique case (ctl.slot)
          4'd0:    pcR[0 +: DATA_W]      <= memRdata;
          4'd1:    pcR[DATA_W +: DATA_W] <= memRdata;
          4'd2:    iyR[0 +: DATA_W]      <= memRdata;
          4'd3:    iyR[DATA_W +: DATA_W] <= memRdata;
          4'd4:    ixR[0 +: DATA_W]      <= memRdata;
          4'd5:    ixR[DATA_W +: DATA_W] <= memRdata;
          4'd6:    aR                    <= memRdata;
          4'd7:    bR                    <= memRdata;
          default: ccrR                  <= memRdata;
        endcase
      end
      if (ctl.vecHi) pcR[DATA_W +: DATA_W] <= memRdata;
      if (ctl.vecLo) pcR[0 +: DATA_W]      <= memRdata;
    end
  end

  assign pcOut   = pcR;
  assign ixOut   = ixR;
  assign iyOut   = iyR;
  assign accAOut = aR;
  assign accBOut = bR;
  assign ccrOut  = ccrR;
  assign spOut   = spR;
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqTake,
  input  logic              reqNmi,
  input  logic              reqTrap,
  input  logic [ADDR_W-1:0] trapPc,
  input  logic [ADDR_W-1:0] vecAddr,
  input  logic              cmdWait,
  input  logic              cmdRti,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] ixIn,
  input  logic [ADDR_W-1:0] iyIn,
  input  logic [DATA_W-1:0] accAIn,
  input  logic [DATA_W-1:0] accBIn,
  input  logic [DATA_W-1:0] ccrIn,
  input  logic [ADDR_W-1:0] spIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] ixOut,
  output logic [ADDR_W-1:0] iyOut,
  output logic [DATA_W-1:0] accAOut,
  output logic [DATA_W-1:0] accBOut,
  output logic [DATA_W-1:0] ccrOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              busy,
  output logic              done,
  output logic              inWait
);
  ctlStrobe_t ctl;

  ctx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqTake(reqTake), .cmdWait(cmdWait),
    .cmdRti(cmdRti), .ctl(ctl), .busy(busy), .done(done), .inWait(inWait)
  );

  ctx_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqNmi(reqNmi), .reqTrap(reqTrap),
    .trapPc(trapPc), .vecAddr(vecAddr), .pcIn(pcIn), .ixIn(ixIn),
    .iyIn(iyIn), .accAIn(accAIn), .accBIn(accBIn), .ccrIn(ccrIn),
    .spIn(spIn), .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe),
    .memRe(memRe), .memWdata(memWdata), .pcOut(pcOut), .ixOut(ixOut),
    .iyOut(iyOut), .accAOut(accAOut), .accBOut(accBOut), .ccrOut(ccrOut),
    .spOut(spOut)
  );
endmodule

// File: rtl/ctx_sequencer_chk.sv
module ctx_sequencer_chk
  import ctx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              memRe,
  input logic [DATA_W-1:0] ccrOut,
  input logic              busy,
  input logic              done,
  input logic              inWait
);
  // R1: pushes walk downward one byte per clock
  p_push_descend_r1: assert property (@(posedge clk) disable iff (!rstN)
    memWe && $past(memWe) |-> memAddr == $past(memAddr) - ADDR_W'(1));

  // R1: never read and write in one cycle
  p_rw_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R5: back-to-back reads outside wait climb by one
  p_pull_ascend_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRe && $past(memRe) && !$past(inWait) |-> memAddr == $past(memAddr) + ADDR_W'(1));

  // R3: once the last push of an entry is done, I is already set
  p_mask_after_stack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWe) && !inWait |-> ccrOut[BIT_I]);

  // R7: parked bus keeps reading one address
  p_wait_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    inWait && $past(inWait) |-> memRe && !memWe && $stable(memAddr));

  // R4: completion pulse only when idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind ctx_sequencer ctx_sequencer_chk u_chk (.*);

// File: tb/sim_ctx_sequencer.sv
`timescale 1ns/1ps
module sim_ctx_sequencer;
  typedef struct packed {
    logic [15:0] pc, ix, iy;
    logic [7:0]  a, b, ccr;
    logic [15:0] sp;
    logic        nmi;
    logic [15:0] vec;
  } row_t;

  localparam int NROWS = 4;
  localparam row_t TBL [0:NROWS-1] = '{
    '{16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h00, 16'h0080, 1'b0, 16'h00F2},
    '{16'hABCD, 16'h0102, 16'h0304, 8'h55, 8'hAA, 8'h00, 16'h00A0, 1'b1, 16'h00F4},
    '{16'hFFFF, 16'h0000, 16'hFFFF, 8'h00, 8'hFF, 8'hD1, 16'h0060, 1'b0, 16'h00F6},
    '{16'h0001, 16'h8000, 16'h7FFF, 8'h7E, 8'h81, 8'h0F, 16'h0050, 1'b1, 16'h00F8}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqTake = 0, reqNmi = 0, reqTrap = 0, cmdWait = 0, cmdRti = 0;
  logic [15:0] trapPc = 0, vecAddr = 0, pcIn = 0, ixIn = 0, iyIn = 0, spIn = 0;
  logic [7:0]  accAIn = 0, accBIn = 0, ccrIn = 0;
  logic [15:0] memAddr, pcOut, ixOut, iyOut, spOut;
  logic [7:0]  memWdata, memRdata, accAOut, accBOut, ccrOut;
  logic memWe, memRe, busy, done, inWait;

  logic [7:0] mem [0:255];
  int checks = 0, failures = 0, cycles = 0, weCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctx_sequencer u0 (.*);

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      summary();
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic loadSnap(input row_t r);
    pcIn = r.pc; ixIn = r.ix; iyIn = r.iy; accAIn = r.a; accBIn = r.b;
    ccrIn = r.ccr; spIn = r.sp; reqNmi = r.nmi; vecAddr = r.vec;
  endtask

  task automatic checkStack(input row_t r, input logic [15:0] savedPc, input string tag);
    logic [7:0] exp [0:8];
    exp[0] = savedPc[7:0]; exp[1] = savedPc[15:8]; exp[2] = r.iy[7:0];
    exp[3] = r.iy[15:8];   exp[4] = r.ix[7:0];     exp[5] = r.ix[15:8];
    exp[6] = r.a;          exp[7] = r.b;           exp[8] = r.ccr;
    for (int k = 0; k < 9; k++) begin
      logic [7:0] got;
      got = mem[8'(r.sp - 16'(k))];
      chk(got == exp[k], tag, {24'd0, got}, {24'd0, exp[k]});
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'hF2] = 8'hC1; mem[8'hF3] = 8'h02;
    mem[8'hF4] = 8'hC3; mem[8'hF5] = 8'h04;
    mem[8'hF6] = 8'hC5; mem[8'hF7] = 8'h06;
    mem[8'hF8] = 8'hC7; mem[8'hF9] = 8'h08;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !inWait && !memWe && !memRe, "R10 reset outputs",
        {27'd0, busy, done, inWait, memWe, memRe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memWe && !memRe, "R10 idle after release",
        {29'd0, busy, memWe, memRe}, 32'd0);

    // table walk: entry then return for each row
    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      logic [7:0] expCcr;
      logic [15:0] expPc;
      r = TBL[i];
      expCcr = r.ccr | 8'h10 | (r.nmi ? 8'h40 : 8'h00);
      expPc = {mem[r.vec[7:0]], mem[8'(r.vec[7:0] + 8'd1)]};
      @(negedge clk) loadSnap(r);
      pulse(reqTake);
      chk(busy, "R9 busy during entry", {31'd0, busy}, 32'd1);
      waitDone();
      chk(done && !busy, "R4 done pulse idle", {30'd0, done, busy}, 32'h2);
      checkStack(r, r.pc, "R1 push order");
      chk(spOut == r.sp - 16'd9, "R2 sp after entry", {16'd0, spOut}, {16'd0, r.sp - 16'd9});
      chk(ccrOut == expCcr, "R3 mask bits", {24'd0, ccrOut}, {24'd0, expCcr});
      chk(pcOut == expPc, "R4 vector pc", {16'd0, pcOut}, {16'd0, expPc});
      // return: scramble snapshot, only sp matters
      @(negedge clk);
      pcIn = 16'hDEAD; ixIn = 16'hBEEF; iyIn = 16'hCAFE;
      accAIn = 8'h5A; accBIn = 8'hA5; ccrIn = 8'h3C; spIn = r.sp - 16'd9;
      pulse(cmdRti);
      waitDone();
      chk(pcOut == r.pc && ixOut == r.ix && iyOut == r.iy, "R5 restore words",
          {pcOut, ixOut}, {r.pc, r.ix});
      chk(accAOut == r.a && accBOut == r.b && ccrOut == r.ccr, "R5 restore bytes",
          {8'd0, accAOut, accBOut, ccrOut}, {8'd0, r.a, r.b, r.ccr});
      chk(spOut == r.sp, "R5 sp after return", {16'd0, spOut}, {16'd0, r.sp});
    end

    // R6: illegal-opcode trap saves opcode address
    begin
      row_t r;
      r = TBL[0];
      r.sp = 16'h0040;
      @(negedge clk) loadSnap(r);
      reqTrap = 1'b1; trapPc = 16'h2040; pcIn = 16'h2042;
      pulse(reqTake);
      reqTrap = 1'b0;
      waitDone();
      checkStack(r, 16'h2040, "R6 trap pc stacked");
    end

    // R7/R8: wait then wake
    begin
      row_t r;
      int weBefore;
      r = TBL[1];
      r.sp = 16'h0070; r.ccr = 8'h00; r.nmi = 1'b0;
      @(negedge clk) loadSnap(r);
      pulse(cmdWait);
      repeat (12) @(negedge clk);
      chk(inWait && busy, "R7 parked", {30'd0, inWait, busy}, 32'h3);
      checkStack(r, r.pc, "R7 wait stacking");
      chk(ccrOut == 8'h00, "R7 masks untouched", {24'd0, ccrOut}, 32'h0);
      for (int k = 0; k < 4; k++) begin
        chk(memRe && !memWe && memAddr == 16'h0068, "R7 flags reread",
            {14'd0, memRe, memWe, memAddr}, {16'h0002, 16'h0068});
        @(negedge clk);
      end
      weBefore = weCount;
      vecAddr = 16'h00F4; reqNmi = 1'b1;
      pulse(reqTake);
      reqNmi = 1'b0;
      waitDone();
      chk(weCount == weBefore, "R8 no restack", weCount, weBefore);
      chk(pcOut == 16'hC304, "R8 vector after wake", {16'd0, pcOut}, 32'h0000C304);
      chk(ccrOut == 8'h50, "R8 mask on wake", {24'd0, ccrOut}, 32'h50);
      chk(spOut == 16'h0067, "R8 sp kept", {16'd0, spOut}, 32'h0067);
    end

    // R9: commands during busy are dropped
    begin
      row_t r;
      r = TBL[2];
      r.sp = 16'h0090;
      @(negedge clk) loadSnap(r);
      pulse(reqTake);
      pulse(cmdRti);
      pulse(cmdWait);
      pulse(reqTake);
      waitDone();
      chk(spOut == 16'h0087 && !inWait, "R9 busy ignores cmds",
          {15'd0, inWait, spOut}, 32'h0087);
      repeat (3) @(negedge clk);
      chk(!busy && !memWe && !memRe, "R9 stays idle",
          {29'd0, busy, memWe, memRe}, 32'd0);
    end

    summary();
  end
endmodule